// File: doc/BRIEF.md
# Write-Only Two-Wire Control Register Bank with Blanking-Gated Mode Switch

This block is a receive-only two-wire (I2C) slave that loads four 8-bit control registers. A bus master sends a start condition, then the 7-bit device address with a write bit, then a register index byte, then one or more data bytes, and finally a stop condition. The block acknowledges every byte it accepts. After each data byte the register index moves up by one, so one transfer can fill several registers in a row.

All fields are decoded onto dedicated output pins. The exception is the 2-bit operating-mode field in register 0, which is double-buffered. A write puts the new mode into a pending copy. The mode output takes that value only while the vertical-sync input and the data-request input are both high. This keeps the block switching in step with an external memory sequencer. Bus lines and the two frame-timing inputs are synchronised into the system clock with two flip-flops each.

Top module: `ctl_i2c_regbank`

## Requirements
- R1: After reset every decoded field output, including `mode_o`, is 0 and `sda_oe` is 0 (SDA released).
- R2: An address byte of 0x2A (device address 0x15, write bit 0) is acknowledged: `sda_oe` pulls SDA low during the ninth SCL pulse.
- R3: An address byte other than 0x2A, including 0x2B (read), is not acknowledged. All later bytes up to the next start are neither acknowledged nor stored.
- R4: The byte after the address selects the register index. Each following data byte is acknowledged and written to the register at the current index.
- R5: The index increments by one after every data byte, so consecutive data bytes fill consecutive registers.
- R6: Data bytes sent to an index of 4 or above are acknowledged but change no register.
- R7: Register 0 drives `frame_narrow_o` from bit 5, `split_o` from bit 3, `vcr_o` from bit 2, `nr_en_o` from bit 1 and `wide8_o` from bit 0. Bit 4 is not stored.
- R8: Register 1 drives `frame_luma_o` from bits 7:5 and `thr_lo_o` from bits 4:0. Register 2 drives `thr_hi_o` from bits 4:0, and its bits 7:5 are not stored.
- R9: Register 3 drives `cls_force_o` from bit 7, `cls_o` from bits 6:5, `coef_force_o` from bit 4 and `coef_o` from bits 3:0.
- R10: Register 0 bits 7:6 (0 normal, 1 multi-picture, 2 still-in-picture, 3 picture-in-still) reach `mode_o` only while `vsync_i` and `dreq_i` are both high. The update happens no more than 3 clocks after both are high.
- R11: `mode_o` keeps its value when only one of `vsync_i` or `dreq_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When 1, pull SDA low (acknowledge) |
| vsync_i | input | 1 | Vertical sync, high during blanking |
| dreq_i | input | 1 | Data request from memory sequencer |
| mode_o | output | 2 | Active operating mode |
| frame_narrow_o | output | 1 | Narrow border enable |
| split_o | output | 1 | Split-screen demonstration enable |
| vcr_o | output | 1 | Tape-source mode, freezes noise adaptation |
| nr_en_o | output | 1 | Noise reduction enable |
| wide8_o | output | 1 | 8-bit (1) or 7-bit (0) input word |
| frame_luma_o | output | 3 | Border grey level, 0 black to 7 white |
| thr_lo_o | output | 5 | Lower noise-class threshold |
| thr_hi_o | output | 5 | Upper noise-class threshold |
| cls_force_o | output | 1 | Force a noise class |
| cls_o | output | 2 | Forced noise class |
| coef_force_o | output | 1 | Force filter coefficient |
| coef_o | output | 4 | Forced coefficient code |

## Verification
A bus edge reaches the edge detector after two synchroniser flops. Its effect is registered one clock later, so the acknowledge drive appears 3 clocks after the SCL falling edge that ends a byte. A register field changes 4 clocks after that edge. `mode_o` follows 3 clocks after `vsync_i` and `dreq_i` are both high. The bench holds each SCL phase for 10 clocks and reads the acknowledge in the middle of the high phase. It checks field outputs only after the stop condition has settled, and it checks `mode_o` 6 clocks after opening a blanking window and again after closing it. These waits are longer than every latency above.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SUB, ST_DATA, ST_ACK, ST_SKIP
  } rx_state_t;

  // bits each register stores; unstored bits read as 0
  function automatic logic [7:0] keep_mask(input int idx);
    case (idx)
      0:       keep_mask = 8'hEF;
      2:       keep_mask = 8'h1F;
      default: keep_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/i2c_wr_rx.sv
module i2c_wr_rx
  import ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h15,
  parameter int         AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  localparam int CW = 4;
  localparam logic [CW-1:0] BITS = CW'(8);

  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;
  logic       scl_rise, scl_fall, start_c, stop_c;

  rx_state_t     st, st_n, kind, kind_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [7:0]    sh, sh_n;
  logic [AW-1:0] ptr, ptr_n;
  logic          oe_n, wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_rise = scl_ff[1] & ~scl_d;
  assign scl_fall = ~scl_ff[1] & scl_d;
  assign start_c  = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
  assign stop_c   = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];

  always_comb begin
    st_n   = st;
    kind_n = kind;
    cnt_n  = cnt;
    sh_n   = sh;
    ptr_n  = ptr;
    oe_n   = sda_oe;
    wr_n   = 1'b0;
    if (wr_en) ptr_n = ptr + 1'b1;
    if (start_c) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_c) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_SUB, ST_DATA: begin
          if (scl_rise && cnt < BITS) begin
            sh_n  = {sh[6:0], sda_ff[1]};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == BITS) begin
            if (st == ST_ADDR) begin
              if (sh == {DEV_ADDR, 1'b0}) begin
                st_n = ST_ACK; oe_n = 1'b1; kind_n = ST_SUB;
              end else begin
                st_n = ST_SKIP;
              end
            end else if (st == ST_SUB) begin
              ptr_n = AW'(sh);
              st_n = ST_ACK; oe_n = 1'b1; kind_n = ST_DATA;
            end else begin
              wr_n = 1'b1;
              st_n = ST_ACK; oe_n = 1'b1; kind_n = ST_DATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            st_n  = kind;
            cnt_n = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      kind   <= ST_SUB;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      wr_en  <= 1'b0;
    end else begin
      st     <= st_n;
      kind   <= kind_n;
      cnt    <= cnt_n;
      sh     <= sh_n;
      ptr    <= ptr_n;
      sda_oe <= oe_n;
      wr_en  <= wr_n;
    end
  end

  assign wr_addr = ptr;
  assign wr_data = sh;

  // R3
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !sda_oe);
  // R4
  data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_oe);
  // R5
  ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !start_c) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import ctl_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 vsync_i,
  input  logic                 dreq_i,
  output logic [NREG-1:0][7:0] regs_o,
  output logic [1:0]           mode_o
);
  logic [1:0] vs_ff, dr_ff;
  logic       win;
  logic [1:0] mode_n;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] nxt;
    always_comb begin
      nxt = regs_o[g];
      if (wr_en && wr_addr == AW'(g)) nxt = wr_data & keep_mask(g);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_o[g] <= '0;
      else        regs_o[g] <= nxt;
    end
  end

  assign win = vs_ff[1] & dr_ff[1];

  always_comb begin
    mode_n = mode_o;
    if (win) mode_n = regs_o[0][7:6];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_ff  <= '0;
      dr_ff  <= '0;
      mode_o <= '0;
    end else begin
      vs_ff  <= {vs_ff[0], vsync_i};
      dr_ff  <= {dr_ff[0], dreq_i};
      mode_o <= mode_n;
    end
  end

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_o) |-> $past(win));
  // R6
  hi_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= AW'(NREG)) |=> $stable(regs_o));
endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank
  import ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h15,
  parameter int         NREG     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       vsync_i,
  input  logic       dreq_i,
  output logic [1:0] mode_o,
  output logic       frame_narrow_o,
  output logic       split_o,
  output logic       vcr_o,
  output logic       nr_en_o,
  output logic       wide8_o,
  output logic [2:0] frame_luma_o,
  output logic [4:0] thr_lo_o,
  output logic [4:0] thr_hi_o,
  output logic       cls_force_o,
  output logic [1:0] cls_o,
  output logic       coef_force_o,
  output logic [3:0] coef_o
);
  localparam int AW = 8;

  logic                 wr_en;
  logic [AW-1:0]        wr_addr;
  logic [7:0]           wr_data;
  logic [NREG-1:0][7:0] regs;

  i2c_wr_rx #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_rx (
    .clk, .rst_n, .scl_i, .sda_i, .sda_oe,
    .wr_en, .wr_addr, .wr_data
  );

  ctl_regs #(.NREG(NREG), .AW(AW)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .vsync_i, .dreq_i, .regs_o(regs), .mode_o
  );

  assign frame_narrow_o = regs[0][5];
  assign split_o        = regs[0][3];
  assign vcr_o          = regs[0][2];
  assign nr_en_o        = regs[0][1];
  assign wide8_o        = regs[0][0];
  assign frame_luma_o   = regs[1][7:5];
  assign thr_lo_o       = regs[1][4:0];
  assign thr_hi_o       = regs[2][4:0];
  assign cls_force_o    = regs[3][7];
  assign cls_o          = regs[3][6:5];
  assign coef_force_o   = regs[3][4];
  assign coef_o         = regs[3][3:0];
endmodule

// File: tb/sim_ctl_i2c_regbank.sv
module sim_ctl_i2c_regbank;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic vsync = 1'b0, dreq = 1'b0;
  logic sda_oe, sda_line;
  logic [1:0] mode_o, cls_o;
  logic frame_narrow_o, split_o, vcr_o, nr_en_o, wide8_o, cls_force_o, coef_force_o;
  logic [2:0] frame_luma_o;
  logic [4:0] thr_lo_o, thr_hi_o;
  logic [3:0] coef_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [4];
  logic [1:0] exp_mode;
  logic [7:0] dbuf [8];

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  ctl_i2c_regbank u0 (
    .clk, .rst_n, .scl_i(scl_m), .sda_i(sda_line), .sda_oe,
    .vsync_i(vsync), .dreq_i(dreq), .mode_o, .frame_narrow_o, .split_o,
    .vcr_o, .nr_en_o, .wide8_o, .frame_luma_o, .thr_lo_o, .thr_hi_o,
    .cls_force_o, .cls_o, .coef_force_o, .coef_o
  );

  function automatic logic [7:0] mask_of(input int i);
    return (i == 0) ? 8'hEF : (i == 2) ? 8'h1F : 8'hFF;
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R7 narrow", frame_narrow_o, exp_r[0][5]);
    chk("R7 split",  split_o,        exp_r[0][3]);
    chk("R7 vcr",    vcr_o,          exp_r[0][2]);
    chk("R7 nr",     nr_en_o,        exp_r[0][1]);
    chk("R7 wide8",  wide8_o,        exp_r[0][0]);
    chk("R8 luma",   frame_luma_o,   exp_r[1][7:5]);
    chk("R8 lo",     thr_lo_o,       exp_r[1][4:0]);
    chk("R8 hi",     thr_hi_o,       exp_r[2][4:0]);
    chk("R9 clsf",   cls_force_o,    exp_r[3][7]);
    chk("R9 cls",    cls_o,          exp_r[3][6:5]);
    chk("R9 coeff",  coef_force_o,   exp_r[3][4]);
    chk("R9 coef",   coef_o,         exp_r[3][3:0]);
    chk("R10 mode",  mode_o,         exp_mode);
  endtask

  task automatic put_bit(input logic b);
    wclk(2); sda_m = b; wclk(H); scl_m = 1'b1; wclk(H); scl_m = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    wclk(2); sda_m = 1'b1; wclk(H); scl_m = 1'b1; wclk(H/2);
    ack = ~sda_line;
    wclk(H/2); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(H); scl_m = 1'b1; wclk(H); sda_m = 1'b0; wclk(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wclk(2); sda_m = 1'b0; wclk(H); scl_m = 1'b1; wclk(H); sda_m = 1'b1; wclk(H);
  endtask

  // one transfer: address byte, index byte, n data bytes from dbuf
  task automatic xfer(input logic [7:0] abyte, input logic [7:0] sub, input int n);
    logic ack;
    bit ok;
    ok = (abyte == 8'h2A);
    bus_start();
    put_byte(abyte, ack);
    chk(ok ? "R2 addr ack" : "R3 addr nack", ack, ok);
    put_byte(sub, ack);
    chk(ok ? "R4 sub ack" : "R3 sub ignored", ack, ok);
    for (int k = 0; k < n; k++) begin
      logic [7:0] a;
      a = sub + 8'(k);
      put_byte(dbuf[k], ack);
      chk(ok ? ((a < 4) ? "R4 data ack" : "R6 data ack") : "R3 data ignored", ack, ok);
      if (ok && a < 4) exp_r[a] = dbuf[k] & mask_of(int'(a));
    end
    bus_stop();
    wclk(8);
  endtask

  task automatic blank(input logic vs, input logic dr);
    vsync = vs; dreq = dr;
    wclk(6);
    if (vs && dr) exp_mode = exp_r[0][7:6];
    chk((vs && dr) ? "R10 mode open" : "R11 mode held", mode_o, exp_mode);
    vsync = 1'b0; dreq = 1'b0;
    wclk(4);
    chk("R10 mode after", mode_o, exp_mode);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4; i++) exp_r[i] = '0;
    exp_mode = '0;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    // R1 reset state
    chk("R1 oe", sda_oe, 0);
    check_all();

    // R7 bit4 dropped, mode held pending
    dbuf[0] = 8'hD5;
    xfer(8'h2A, 8'h00, 1);
    check_all();
    blank(1'b1, 1'b0);
    blank(1'b0, 1'b1);
    blank(1'b1, 1'b1);
    chk("R10 mode 3", mode_o, 3);

    // R5 run over 1..3, R8 upper bits of reg 2 dropped
    dbuf[0] = 8'hA7; dbuf[1] = 8'hFF; dbuf[2] = 8'h3C;
    xfer(8'h2A, 8'h01, 3);
    check_all();

    // R6 index runs past the last register
    dbuf[0] = 8'h96; dbuf[1] = 8'h11; dbuf[2] = 8'h22;
    xfer(8'h2A, 8'h03, 3);
    check_all();

    // R3 wrong address and read bit
    dbuf[0] = 8'h00; dbuf[1] = 8'h00;
    xfer(8'h2C, 8'h00, 2);
    check_all();
    xfer(8'h2B, 8'h01, 2);
    check_all();

    // random mix
    for (int t = 0; t < 30; t++) begin
      int n;
      logic [7:0] ab;
      n  = 1 + int'($urandom_range(0, 3));
      ab = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(0, 255)) : 8'h2A;
      for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom_range(0, 255));
      xfer(ab, 8'($urandom_range(0, 5)), n);
      check_all();
      blank(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule